// File: doc/BRIEF.md
# Tick Timer Unit

The tick timer unit combines a reloadable down-counting tick generator with a free-running 32-bit timestamp counter. Both sit behind a small word-wide register bus. Software programs a period and a couple of mode flags in one control word. The down-counter then runs on each cycle in which the timer clock enable is high. Every expiry latches a pending flag, and that flag drives the interrupt output until software writes a one to clear it.

The timestamp counter advances at the same enabled rate, whether or not the tick generator is enabled. Software can write it at any time, most often with zero. This lets an interrupt handler measure how far real time has moved since the last tick it serviced.

The bus has one write strobe. Reads are combinational: the word at the current address is presented, and reading never changes any state. Register select codes on `bus_addr` are: 0 control word, 1 status, 2 timestamp, 3 current down-count (read-only, writes ignored).

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, every readable register returns 0 and `tick_irq` is low.
- R2: Control word (select 0) bit 0 is the enable and bit 1 selects one-shot mode. The count value is the written word with bits 1:0 forced to 0. Any write to the control word loads the down-counter (select 3) with the count value at the next clock edge. Read-back returns the word as written.
- R3: While enabled and `tick_en` is high, the down-counter falls by one per cycle. If the timer is disabled or `tick_en` is low, it holds.
- R4: In periodic mode (bit 1 = 0), an enabled tick that finds the counter at 0 is an expiry, and the counter reloads the count value. The interval between expiries is therefore count value + 1 enabled ticks.
- R5: In one-shot mode (bit 1 = 1), an expiry leaves the counter at 0 and clears control bit 0. The timer stays stopped after that.
- R6: An expiry sets status bit 0 (pending) at the same edge. `tick_irq` equals the pending bit.
- R7: Writing status with bit 0 = 1 clears pending. Writing bit 0 = 0 leaves it unchanged.
- R8: If an expiry and a clearing write to status fall in the same cycle, pending stays set.
- R9: The timestamp (select 2) increases by one on every cycle with `tick_en` high, regardless of the timer enable. A write loads the written value; writing 0 resets it. A write takes priority over the increment. It holds while `tick_en` is low.
- R10: The timestamp wraps from 0xFFFFFFFF to 0x00000000.
- R11: Reading any register has no effect on pending, on the counter or on the timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer clock enable; one timer tick per high cycle |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| tick_irq | output | 1 | Tick interrupt, high while pending is set |

## Verification
Every state element is a single register stage, so a write or tick takes effect at the first rising edge after the stimulus. A read reflects that edge at once, because the read path is combinational. The bench drives stimulus at falling edges and samples one falling edge later. When it waits n cycles, it expects exactly n decrements or increments. Expiry is predicted at the count value + 1 edge after the control write. The collision case is aligned by arriving at the cycle where the counter reads 0 and issuing the clearing write there, so that write meets the expiry edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_STAMP  = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    // Control word flag layout
    localparam int FLAG_BITS   = 2;
    localparam int ENABLE_BIT  = 0;
    localparam int ONESHOT_BIT = 1;

    // Status word layout
    localparam int PEND_BIT    = 0;

endpackage

// File: rtl/tmr_reload_ctrl.sv
module tmr_reload_ctrl
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q_o,
    output logic [DATA_W-1:0] cnt_q_o,
    output logic              expire_o
);

    localparam logic [DATA_W-1:0] CNT_MASK =
        {{(DATA_W-FLAG_BITS){1'b1}}, {FLAG_BITS{1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   run;
    logic   expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        run    = st_q.ctrl[ENABLE_BIT] && tick_en;
        if (wr_ctrl) begin
            // A bus write wins over any tick in the same cycle
            st_d.ctrl = wdata;
            st_d.cnt  = wdata & CNT_MASK;
        end else if (run) begin
            if (st_q.cnt == '0) begin
                expire = 1'b1;
                if (st_q.ctrl[ONESHOT_BIT]) begin
                    st_d.ctrl[ENABLE_BIT] = 1'b0;
                end else begin
                    st_d.cnt = st_q.ctrl & CNT_MASK;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q_o = st_q.ctrl;
    assign cnt_q_o  = st_q.cnt;
    assign expire_o = expire;

    // R2: a control write loads the masked count value
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (st_q.cnt == ($past(wdata) & CNT_MASK)));

    // R3: enabled tick with nonzero count decrements by one
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[ENABLE_BIT] && tick_en && !wr_ctrl && st_q.cnt != '0)
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R3: no tick and no write leaves the counter alone
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_ctrl) |=> $stable(st_q.cnt));

    // R4: periodic expiry reloads from the control word
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !st_q.ctrl[ONESHOT_BIT])
        |=> (st_q.cnt == ($past(st_q.ctrl) & CNT_MASK)));

    // R5: one-shot expiry stops at zero with enable dropped
    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && st_q.ctrl[ONESHOT_BIT])
        |=> (!st_q.ctrl[ENABLE_BIT] && st_q.cnt == '0));

endmodule

// File: rtl/tmr_pend_status.sv
module tmr_pend_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    output logic pend_q_o
);

    typedef struct packed {
        logic pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire) begin
            // Set has priority over a simultaneous clear
            st_d.pend = 1'b1;
        end else if (clr_req) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q_o = st_q.pend;

    // R6 / R8: expiry always leaves pending set, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.pend);

    // R7: a clearing write without expiry drops pending
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expire) |=> !st_q.pend);

    // R7 / R11: pending changes only on expiry or a clearing write
    a_r11_pend_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !expire) |=> $stable(st_q.pend));

endmodule

// File: rtl/tmr_stamp_counter.sv
module tmr_stamp_counter #(
    parameter int STAMP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               wr_stamp,
    input  logic [STAMP_W-1:0] wdata,
    output logic [STAMP_W-1:0] stamp_q_o
);

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stamp) begin
            st_d.stamp = wdata;
        end else if (tick_en) begin
            // Natural modulo-2^STAMP_W wrap
            st_d.stamp = st_q.stamp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp_q_o = st_q.stamp;

    // R9 / R10: one step per enabled cycle, wrapping at the top
    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_stamp) |=> (st_q.stamp == $past(st_q.stamp) + 1'b1));

    // R9: a write loads the written value
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stamp |=> (st_q.stamp == $past(wdata)));

    // R9: no enable and no write holds the count
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_stamp) |=> $stable(st_q.stamp));

endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);

    reg_sel_e          sel;
    logic              wr_ctrl;
    logic              wr_status;
    logic              wr_stamp;
    logic              clr_req;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] stamp_q;
    logic              expire;
    logic              pend_q;

    always_comb begin
        sel       = reg_sel_e'(bus_addr);
        wr_ctrl   = bus_wr && (sel == SEL_CTRL);
        wr_status = bus_wr && (sel == SEL_STATUS);
        wr_stamp  = bus_wr && (sel == SEL_STAMP);
        clr_req   = wr_status && bus_wdata[PEND_BIT];
    end

    tmr_reload_ctrl #(
        .DATA_W (DATA_W)
    ) reload_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_ctrl  (wr_ctrl),
        .wdata    (bus_wdata),
        .ctrl_q_o (ctrl_q),
        .cnt_q_o  (cnt_q),
        .expire_o (expire)
    );

    tmr_pend_status pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .clr_req  (clr_req),
        .pend_q_o (pend_q)
    );

    tmr_stamp_counter #(
        .STAMP_W (DATA_W)
    ) stamp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_stamp  (wr_stamp),
        .wdata     (bus_wdata),
        .stamp_q_o (stamp_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL:   bus_rdata = ctrl_q;
            SEL_STATUS: bus_rdata[PEND_BIT] = pend_q;
            SEL_STAMP:  bus_rdata = stamp_q;
            SEL_COUNT:  bus_rdata = cnt_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign tick_irq = pend_q;

    // R6: interrupt rises only in the cycle after an expiry
    a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_irq) |-> $past(expire));

endmodule

// File: tb/tick_timer_unit_tb_top.sv
module tick_timer_unit_tb_top;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_STATUS = 2'd1;
    localparam logic [1:0] A_STAMP  = 2'd2;
    localparam logic [1:0] A_COUNT  = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_timer_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_irq  (tick_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic test_reset;
        logic [31:0] v;
        bus_read(A_CTRL, v);   check("R1 ctrl", v, 32'h0);
        bus_read(A_STATUS, v); check("R1 status", v, 32'h0);
        bus_read(A_STAMP, v);  check("R1 stamp", v, 32'h0);
        bus_read(A_COUNT, v);  check("R1 count", v, 32'h0);
        check("R1 irq", {31'b0, tick_irq}, 32'h0);
    endtask

    task automatic test_disabled_hold;
        logic [31:0] v;
        tick_en = 1'b1;
        bus_write(A_CTRL, 32'h10);
        bus_read(A_COUNT, v); check("R2 load on write", v, 32'd16);
        wait_cycles(5);
        bus_read(A_COUNT, v); check("R3 disabled hold", v, 32'd16);
        bus_read(A_CTRL, v);  check("R2 readback", v, 32'h10);
        check("R6 no irq when disabled", {31'b0, tick_irq}, 32'h0);
    endtask

    task automatic test_periodic;
        logic [31:0] v;
        bus_write(A_CTRL, 32'h11);
        wait_cycles(10);
        bus_read(A_COUNT, v); check("R3 decrement", v, 32'd6);
        check("R6 irq low before expiry", {31'b0, tick_irq}, 32'h0);
        wait_cycles(7);
        bus_read(A_STATUS, v); check("R6 pending on expiry", v, 32'h1);
        check("R6 irq follows pending", {31'b0, tick_irq}, 32'h1);
        bus_read(A_COUNT, v); check("R4 reload", v, 32'd16);
        bus_write(A_STATUS, 32'h0);
        bus_read(A_STATUS, v); check("R7 zero write ignored", v, 32'h1);
        bus_write(A_STATUS, 32'h1);
        bus_read(A_STATUS, v); check("R7 clear", v, 32'h0);
        bus_read(A_COUNT, v); check("R4 running after clear", v, 32'd14);
        bus_write(A_CTRL, 32'h21);
        bus_read(A_COUNT, v); check("R2 load while enabled", v, 32'h20);
        wait_cycles(3);
        bus_read(A_COUNT, v); check("R3 decrement after load", v, 32'h1D);
        bus_write(A_CTRL, 32'h1D);
        bus_read(A_COUNT, v); check("R2 flag bits masked", v, 32'h1C);
        bus_read(A_CTRL, v);  check("R2 readback with flags", v, 32'h1D);
    endtask

    task automatic test_tick_pause;
        logic [31:0] v;
        logic [31:0] s0;
        tick_en = 1'b0;
        bus_read(A_STAMP, s0);
        wait_cycles(5);
        bus_read(A_COUNT, v); check("R3 hold on tick_en low", v, 32'h1C);
        bus_read(A_STAMP, v); check("R9 stamp hold on tick_en low", v, s0);
        tick_en = 1'b1;
    endtask

    task automatic test_oneshot;
        logic [31:0] v;
        bus_write(A_CTRL, 32'h7);
        bus_read(A_COUNT, v); check("R5 load", v, 32'd4);
        wait_cycles(4);
        bus_read(A_COUNT, v); check("R5 at zero", v, 32'd0);
        bus_read(A_STATUS, v); check("R5 no pending yet", v, 32'h0);
        wait_cycles(1);
        bus_read(A_STATUS, v); check("R5 pending on expiry", v, 32'h1);
        bus_read(A_CTRL, v); check("R5 enable cleared", v, 32'h6);
        wait_cycles(3);
        bus_read(A_COUNT, v); check("R5 stays at zero", v, 32'd0);
        bus_write(A_STATUS, 32'h1);
        bus_read(A_STATUS, v); check("R7 clear after one-shot", v, 32'h0);
        check("R5 no refire", {31'b0, tick_irq}, 32'h0);
    endtask

    task automatic test_collision;
        logic [31:0] v;
        bus_write(A_CTRL, 32'h5);
        wait_cycles(4);
        bus_read(A_COUNT, v); check("R8 counter at zero", v, 32'd0);
        bus_write(A_STATUS, 32'h1);
        bus_read(A_STATUS, v); check("R8 set wins over clear", v, 32'h1);
        bus_read(A_COUNT, v); check("R8 reload on collision", v, 32'd4);
        bus_write(A_STATUS, 32'h1);
        bus_read(A_STATUS, v); check("R8 later clear works", v, 32'h0);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic test_read_no_effect;
        logic [31:0] v;
        logic [31:0] s0;
        bus_write(A_CTRL, 32'h1);
        wait_cycles(1);
        check("R6 zero period expires", {31'b0, tick_irq}, 32'h1);
        tick_en = 1'b0;
        bus_write(A_CTRL, 32'h0);
        bus_read(A_STAMP, s0);
        for (int i = 0; i < 4; i++) begin
            bus_read(A_STATUS, v);
            bus_read(A_COUNT, v);
            bus_read(A_CTRL, v);
            bus_read(A_STAMP, v);
            wait_cycles(1);
        end
        bus_read(A_STATUS, v); check("R11 pending kept across reads", v, 32'h1);
        bus_read(A_STAMP, v);  check("R11 stamp kept across reads", v, s0);
        bus_write(A_STATUS, 32'h1);
        tick_en = 1'b1;
    endtask

    task automatic test_stamp;
        logic [31:0] v;
        bus_write(A_STAMP, 32'h0);
        bus_read(A_STAMP, v); check("R9 write zero", v, 32'h0);
        wait_cycles(7);
        bus_read(A_STAMP, v); check("R9 free running", v, 32'd7);
        bus_write(A_STAMP, 32'hFFFF_FFFE);
        bus_read(A_STAMP, v); check("R9 write value", v, 32'hFFFF_FFFE);
        wait_cycles(1);
        bus_read(A_STAMP, v); check("R10 top value", v, 32'hFFFF_FFFF);
        wait_cycles(1);
        bus_read(A_STAMP, v); check("R10 wrap", v, 32'h0);
        wait_cycles(1);
        bus_read(A_STAMP, v); check("R10 after wrap", v, 32'h1);
        bus_write(A_COUNT, 32'h44);
        bus_read(A_COUNT, v); check("R2 count select read-only", v, 32'h0);
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        test_reset();
        test_disabled_hold();
        test_periodic();
        test_tick_pause();
        test_oneshot();
        test_collision();
        test_read_no_effect();
        test_stamp();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule